// File: doc/BRIEF.md
# Compressed Quadrant-1 Instruction Expander

This block turns a 16-bit compressed RISC-V instruction from quadrant 1 (low two bits `01`) into the equivalent 32-bit base-ISA instruction. It is purely combinational and sits between instruction alignment and the main decoder. Downstream logic therefore only ever sees full-length encodings. Alongside the expanded word it raises an illegal flag for reserved or out-of-quadrant encodings. Whenever the flag is set, the expanded word is forced to zero.

A static `XLEN` parameter (32 or 64) chooses the meaning of the opcodes that differ between the two base widths. On RV32, funct3 `001` is a jump-and-link. On RV64 it is a word-sized add-immediate. The word register ops and the sixth shift-amount bit are legal only on RV64. Hint encodings expand into ordinary instructions that leave no architectural trace.

Top module: `rvc1_expander`

## Requirements
- R1: An input whose bits 1:0 are not `01` sets `illegal_o`. Whenever `illegal_o` is 1, `instr_o` is all zeros.
- R2: funct3 (bits 15:13) `000` gives `addi rd,rd,imm` and `010` gives `addi rd,x0,imm`. funct3 `100` with bits 11:10 = `10` gives `andi rd',rd',imm`. Here imm is the 6-bit value {b12,b6:2} sign-extended to 12 bits, and rd is bits 11:7. ADDI with a zero immediate stays legal.
- R3: funct3 `001` gives `jal x1,offset` when XLEN=32. It gives `addiw rd,rd,imm` (opcode 0x1B) when XLEN=64.
- R4: funct3 `101` gives `jal x0,offset`. The offset is sign-extended from {b12,b8,b10:9,b6,b7,b2,b11,b5:3,0}, listed from bit 11 down to bit 0.
- R5: funct3 `110`/`111` give `beq`/`bne rs1',x0,offset`. The offset is sign-extended from {b12,b6:5,b2,b11:10,b4:3,0}, listed from bit 8 down to bit 0.
- R6: funct3 `011` with rd=2 gives `addi x2,x2,imm`. The immediate is sign-extended from {b12,b4:3,b5,b2,b6,0000}, listed from bit 9 down to bit 0. An all-zero immediate is illegal.
- R7: funct3 `011` with rd≠2 gives `lui rd,imm`, with the 20-bit upper immediate sign-extended from {b12,b6:2}. A zero immediate is illegal. rd=0 stays legal.
- R8: funct3 `100` with bits 11:10 = `00`/`01` gives `srli`/`srai rd',rd',{b12,b6:2}`, with funct7 high bits `000000`/`010000`. When XLEN=32, b12=1 is illegal.
- R9: funct3 `100`, bits 11:10 = `11`, b12=0: bits 6:5 = `00`,`01`,`10`,`11` select `sub`,`xor`,`or`,`and rd',rd',rs2'` (opcode 0x33).
- R10: With b12=1 in that group, bits 6:5 = `00`/`01` give `subw`/`addw` (opcode 0x3B) when XLEN=64 and are illegal when XLEN=32. Bits 6:5 = `10`/`11` are illegal for both widths.
- R11: The 3-bit register fields rd'/rs1' (bits 9:7) and rs2' (bits 4:2) name x8 to x15 (binary `01` prefixed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Compressed instruction |
| instr_o | output | 32 | Expanded base instruction, zero when illegal |
| illegal_o | output | 1 | Reserved, out-of-quadrant or width-illegal encoding |

## Verification
The block holds no state, so any mis-decode or mis-scattered immediate appears at the ports in the same cycle the compressed word is presented. It does not persist to the next input. A wrong class selection shows as a wrong opcode, funct3 or funct7 field, or as a spurious illegal flag. A wrong bit route shows as a single displaced immediate bit. The test words therefore place ones in distinct offset positions and use both signs, so that each scattered bit is visible. Every input is applied to one instance of each width.

// File: rtl/rvc1_pkg.sv
// Shared constants, kinds and encoders for the quadrant-1 expander.
// Assumes the base-ISA opcode values of the standard 32-bit encoding.
package rvc1_pkg;

    localparam int CLEN = 16;
    localparam int ILEN = 32;
    localparam int RLEN = 5;
    localparam int CRLEN = 3;

    localparam logic [6:0] OPC_OP_IMM   = 7'h13;
    localparam logic [6:0] OPC_OP_IMM32 = 7'h1B;
    localparam logic [6:0] OPC_LUI      = 7'h37;
    localparam logic [6:0] OPC_JAL      = 7'h6F;
    localparam logic [6:0] OPC_BRANCH   = 7'h63;
    localparam logic [6:0] OPC_OP       = 7'h33;
    localparam logic [6:0] OPC_OP32     = 7'h3B;

    localparam logic [6:0] F7_BASE = 7'h00;
    localparam logic [6:0] F7_ALT  = 7'h20;

    localparam logic [1:0] CREG_BANK = 2'b01;
    localparam logic [RLEN-1:0] REG_ZERO = 5'd0;
    localparam logic [RLEN-1:0] REG_LINK = 5'd1;
    localparam logic [RLEN-1:0] REG_SP   = 5'd2;

    typedef enum logic [4:0] {
        XK_BAD, XK_ADDI, XK_ADDIW, XK_JAL, XK_LI, XK_SPADJ, XK_LUI,
        XK_SRLI, XK_SRAI, XK_ANDI, XK_SUB, XK_XOR, XK_OR, XK_AND,
        XK_SUBW, XK_ADDW, XK_J, XK_BEQZ, XK_BNEZ
    } xkind_e;

    typedef struct packed {
        logic [11:0] imm_i;
        logic [11:0] imm_sp;
        logic [19:0] imm_u;
        logic [20:0] imm_j;
        logic [12:0] imm_b;
        logic [5:0]  shamt;
    } imm_set_t;

    function automatic logic [ILEN-1:0] pack_i(input logic [11:0] imm, input logic [4:0] rs1,
                                               input logic [2:0] f3, input logic [4:0] rd,
                                               input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [ILEN-1:0] pack_r(input logic [6:0] f7, input logic [4:0] rs2,
                                               input logic [4:0] rs1, input logic [2:0] f3,
                                               input logic [4:0] rd, input logic [6:0] opc);
        return {f7, rs2, rs1, f3, rd, opc};
    endfunction

    function automatic logic [ILEN-1:0] pack_u(input logic [19:0] imm, input logic [4:0] rd);
        return {imm, rd, OPC_LUI};
    endfunction

    function automatic logic [ILEN-1:0] pack_j(input logic [20:0] off, input logic [4:0] rd);
        return {off[20], off[10:1], off[11], off[19:12], rd, OPC_JAL};
    endfunction

    function automatic logic [ILEN-1:0] pack_b(input logic [12:0] off, input logic [4:0] rs1,
                                               input logic [2:0] f3);
        return {off[12], off[10:5], REG_ZERO, rs1, f3, off[4:1], off[11], OPC_BRANCH};
    endfunction

endpackage

// File: rtl/rvc1_imm_unpack.sv
// Gathers the scattered immediate bits of every quadrant-1 format into
// sign-extended base-format immediates. Assumes bits 12:2 of the halfword.
module rvc1_imm_unpack
    import rvc1_pkg::*;
(
    input  logic [12:2] fld_i,
    output imm_set_t    imm_o
);

    logic [11:0] j_raw;
    logic [8:0]  b_raw;
    logic [9:0]  sp_raw;
    logic [5:0]  ci_raw;

    // Reassemble the raw offsets in natural bit order.
    always_comb begin
        ci_raw = {fld_i[12], fld_i[6:2]};
        j_raw  = {fld_i[12], fld_i[8], fld_i[10:9], fld_i[6], fld_i[7],
                  fld_i[2], fld_i[11], fld_i[5:3], 1'b0};
        b_raw  = {fld_i[12], fld_i[6:5], fld_i[2], fld_i[11:10], fld_i[4:3], 1'b0};
        sp_raw = {fld_i[12], fld_i[4:3], fld_i[5], fld_i[2], fld_i[6], 4'b0000};
    end

    // Sign-extend each raw value to its base-format width.
    always_comb begin
        imm_o.imm_i  = {{6{ci_raw[5]}}, ci_raw};
        imm_o.imm_u  = {{14{ci_raw[5]}}, ci_raw};
        imm_o.shamt  = ci_raw;
        imm_o.imm_sp = {{2{sp_raw[9]}}, sp_raw};
        imm_o.imm_j  = {{9{j_raw[11]}}, j_raw};
        imm_o.imm_b  = {{4{b_raw[8]}}, b_raw};
    end

endmodule

// File: rtl/rvc1_classify.sv
// Selects the expansion kind of a halfword, or XK_BAD when it is reserved,
// outside quadrant 1 or not legal for the chosen XLEN (32 or 64).
module rvc1_classify
    import rvc1_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [CLEN-1:0] c_i,
    output xkind_e          kind_o
);

    localparam bit IS_WIDE = (XLEN == 64);

    xkind_e f1_kind;
    logic   wide_ok;

    // Width-dependent choices are fixed at elaboration.
    generate
        if (IS_WIDE) begin : g_wide
            assign f1_kind = XK_ADDIW;
            assign wide_ok = 1'b1;
        end else begin : g_narrow
            assign f1_kind = XK_JAL;
            assign wide_ok = 1'b0;
        end
    endgenerate

    logic nz6;
    logic rd_sp;
    logic sh_ok;

    // Field predicates shared by several opcodes.
    always_comb begin
        nz6   = c_i[12] | (|c_i[6:2]);
        rd_sp = (c_i[11:7] == REG_SP);
        sh_ok = wide_ok | ~c_i[12];
    end

    // Main opcode tree.
    always_comb begin
        kind_o = XK_BAD;
        if (c_i[1:0] == 2'b01) begin
            unique case (c_i[15:13])
                3'b000: kind_o = XK_ADDI;
                3'b001: kind_o = f1_kind;
                3'b010: kind_o = XK_LI;
                3'b011: kind_o = !nz6 ? XK_BAD : (rd_sp ? XK_SPADJ : XK_LUI);
                3'b100: begin
                    unique case (c_i[11:10])
                        2'b00: kind_o = sh_ok ? XK_SRLI : XK_BAD;
                        2'b01: kind_o = sh_ok ? XK_SRAI : XK_BAD;
                        2'b10: kind_o = XK_ANDI;
                        default: begin
                            unique case ({c_i[12], c_i[6:5]})
                                3'b000: kind_o = XK_SUB;
                                3'b001: kind_o = XK_XOR;
                                3'b010: kind_o = XK_OR;
                                3'b011: kind_o = XK_AND;
                                3'b100: kind_o = wide_ok ? XK_SUBW : XK_BAD;
                                3'b101: kind_o = wide_ok ? XK_ADDW : XK_BAD;
                                default: kind_o = XK_BAD;
                            endcase
                        end
                    endcase
                end
                3'b101: kind_o = XK_J;
                3'b110: kind_o = XK_BEQZ;
                default: kind_o = XK_BNEZ;
            endcase
        end
    end

endmodule

// File: rtl/rvc1_assemble.sv
// Builds the 32-bit word for a given kind from the unpacked immediates and
// register fields. Assumes XK_BAD must yield an all-zero word.
module rvc1_assemble
    import rvc1_pkg::*;
(
    input  xkind_e          kind_i,
    input  imm_set_t        imm_i,
    input  logic [4:0]      rd_i,
    input  logic [2:0]      rp1_i,
    input  logic [2:0]      rp2_i,
    output logic [ILEN-1:0] word_o
);

    logic [RLEN-1:0] r1;
    logic [RLEN-1:0] r2;

    // Widen the short register fields into the x8..x15 bank.
    always_comb begin
        r1 = {CREG_BANK, rp1_i};
        r2 = {CREG_BANK, rp2_i};
    end

    // Encode the base instruction per kind.
    always_comb begin
        unique case (kind_i)
            XK_ADDI:  word_o = pack_i(imm_i.imm_i, rd_i, 3'b000, rd_i, OPC_OP_IMM);
            XK_ADDIW: word_o = pack_i(imm_i.imm_i, rd_i, 3'b000, rd_i, OPC_OP_IMM32);
            XK_JAL:   word_o = pack_j(imm_i.imm_j, REG_LINK);
            XK_LI:    word_o = pack_i(imm_i.imm_i, REG_ZERO, 3'b000, rd_i, OPC_OP_IMM);
            XK_SPADJ: word_o = pack_i(imm_i.imm_sp, REG_SP, 3'b000, REG_SP, OPC_OP_IMM);
            XK_LUI:   word_o = pack_u(imm_i.imm_u, rd_i);
            XK_SRLI:  word_o = pack_i({6'b000000, imm_i.shamt}, r1, 3'b101, r1, OPC_OP_IMM);
            XK_SRAI:  word_o = pack_i({6'b010000, imm_i.shamt}, r1, 3'b101, r1, OPC_OP_IMM);
            XK_ANDI:  word_o = pack_i(imm_i.imm_i, r1, 3'b111, r1, OPC_OP_IMM);
            XK_SUB:   word_o = pack_r(F7_ALT,  r2, r1, 3'b000, r1, OPC_OP);
            XK_XOR:   word_o = pack_r(F7_BASE, r2, r1, 3'b100, r1, OPC_OP);
            XK_OR:    word_o = pack_r(F7_BASE, r2, r1, 3'b110, r1, OPC_OP);
            XK_AND:   word_o = pack_r(F7_BASE, r2, r1, 3'b111, r1, OPC_OP);
            XK_SUBW:  word_o = pack_r(F7_ALT,  r2, r1, 3'b000, r1, OPC_OP32);
            XK_ADDW:  word_o = pack_r(F7_BASE, r2, r1, 3'b000, r1, OPC_OP32);
            XK_J:     word_o = pack_j(imm_i.imm_j, REG_ZERO);
            XK_BEQZ:  word_o = pack_b(imm_i.imm_b, r1, 3'b000);
            XK_BNEZ:  word_o = pack_b(imm_i.imm_b, r1, 3'b001);
            default:  word_o = '0;
        endcase
    end

endmodule

// File: rtl/rvc1_expander.sv
// Top of the quadrant-1 expander: classify, unpack immediates, assemble.
// Purely combinational; XLEN must be 32 or 64.
module rvc1_expander
    import rvc1_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [15:0] instr_i,
    output logic [31:0] instr_o,
    output logic        illegal_o
);

    xkind_e   kind;
    imm_set_t imms;

    rvc1_classify #(.XLEN(XLEN)) u_cls (
        .c_i    (instr_i),
        .kind_o (kind)
    );

    rvc1_imm_unpack u_imm (
        .fld_i (instr_i[12:2]),
        .imm_o (imms)
    );

    rvc1_assemble u_asm (
        .kind_i (kind),
        .imm_i  (imms),
        .rd_i   (instr_i[11:7]),
        .rp1_i  (instr_i[9:7]),
        .rp2_i  (instr_i[4:2]),
        .word_o (instr_o)
    );

    // Flag any encoding the classifier rejected.
    always_comb illegal_o = (kind == XK_BAD);

endmodule

// File: rtl/rvc1_expander_chk.sv
// Port-level checks for rvc1_expander, attached by bind below.
// Assumes the port encodings listed in the requirements.
module rvc1_expander_chk #(
    parameter int XLEN = 32
) (
    input logic [1:0]  c_quad,
    input logic [2:0]  c_f3,
    input logic [2:0]  c_b12_10,
    input logic [4:0]  c_rd,
    input logic [31:0] x_word,
    input logic        x_bad
);

    // Evaluate the relations whenever the ports settle.
    always_comb begin
        // R1
        if (x_bad) zero_on_bad_chk: assert (x_word == 32'h0);
        // R1
        if (c_quad != 2'b01) quad_gate_chk: assert (x_bad);
        // R4
        if (!x_bad && c_f3 == 3'b101)
            jump_link_chk: assert (x_word[6:0] == 7'h6F && x_word[11:7] == 5'd0);
        // R5
        if (!x_bad && c_f3[2:1] == 2'b11)
            branch_zero_chk: assert (x_word[6:0] == 7'h63 && x_word[24:20] == 5'd0
                                     && x_word[14:13] == 2'b00);
        // R6
        if (!x_bad && c_f3 == 3'b011 && c_rd == 5'd2)
            sp_adjust_chk: assert (x_word[19:15] == 5'd2 && x_word[23:20] == 4'h0);
        // R8
        if (XLEN == 32 && !x_bad && c_f3 == 3'b100 && c_b12_10[1] == 1'b0)
            narrow_shamt_chk: assert (x_word[25] == 1'b0 && x_word[14:12] == 3'b101
                                      && (x_word[31:26] == 6'b000000 || x_word[31:26] == 6'b010000));
        // R11
        if (!x_bad && c_f3 == 3'b100 && c_b12_10[1:0] == 2'b11)
            short_reg_chk: assert (x_word[19:18] == 2'b01 && x_word[11:10] == 2'b01);
    end

endmodule

bind rvc1_expander rvc1_expander_chk #(.XLEN(XLEN)) u_chk (
    .c_quad   (instr_i[1:0]),
    .c_f3     (instr_i[15:13]),
    .c_b12_10 (instr_i[12:10]),
    .c_rd     (instr_i[11:7]),
    .x_word   (instr_o),
    .x_bad    (illegal_o)
);

// File: tb/sim_rvc1_expander.sv
// Scoreboard bench: one RV32 instance (u0) and one RV64 instance (u1).
`timescale 1ns/1ps
module sim_rvc1_expander;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [15:0] cin;
    logic [31:0] w32, w64;
    logic        b32, b64;

    rvc1_expander #(.XLEN(32)) u0 (.instr_i(cin), .instr_o(w32), .illegal_o(b32));
    rvc1_expander #(.XLEN(64)) u1 (.instr_i(cin), .instr_o(w64), .illegal_o(b64));

    typedef struct {
        logic [15:0] c;
        logic [31:0] e32;
        logic        i32;
        logic [31:0] e64;
        logic        i64;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Compressed-word builders (bench side).
    function automatic logic [15:0] c_ci(input logic [2:0] f3, input logic [4:0] rd, input logic [5:0] im);
        return {f3, im[5], rd, im[4:0], 2'b01};
    endfunction
    function automatic logic [15:0] c_cj(input logic [2:0] f3, input logic [11:0] o);
        return {f3, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
    endfunction
    function automatic logic [15:0] c_cb(input logic [2:0] f3, input logic [2:0] rp, input logic [8:0] o);
        return {f3, o[8], o[4:3], rp, o[7:6], o[2:1], o[5], 2'b01};
    endfunction
    function automatic logic [15:0] c_sp(input logic [9:0] im);
        return {3'b011, im[9], 5'd2, im[4], im[6], im[8:7], im[5], 2'b01};
    endfunction
    function automatic logic [15:0] c_grp(input logic b12, input logic [1:0] hi, input logic [2:0] rp,
                                          input logic [4:0] lo);
        return {3'b100, b12, hi, rp, lo, 2'b01};
    endfunction

    // Base-word builders (bench side).
    function automatic logic [31:0] e_i(input logic [11:0] im, input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] op);
        return {im, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [4:0] rs2, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [6:0] op);
        return {f7, rs2, rs1, f3, rs1, op};
    endfunction
    function automatic logic [31:0] e_j(input logic [20:0] o, input logic [4:0] rd);
        return {o[20], o[10:1], o[11], o[19:12], rd, 7'h6F};
    endfunction
    function automatic logic [31:0] e_b(input logic [12:0] o, input logic [4:0] rs1, input logic [2:0] f3);
        return {o[12], o[10:5], 5'd0, rs1, f3, o[4:1], o[11], 7'h63};
    endfunction

    // Driver: apply a word and push the expected pair.
    task automatic push(input logic [15:0] c, input logic [31:0] e32, input logic i32,
                        input logic [31:0] e64, input logic i64, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        cin = c;
        it.c = c; it.e32 = i32 ? 32'h0 : e32; it.i32 = i32;
        it.e64 = i64 ? 32'h0 : e64; it.i64 = i64; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic same(input logic [15:0] c, input logic [31:0] e, input logic ill, input string tag);
        push(c, e, ill, e, ill, tag);
    endtask

    // Monitor: compare both widths away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk += 2;
            if (w32 !== it.e32 || b32 !== it.i32) begin
                n_err++;
                $display("FAIL %s rv32 c=%h: got %h/%b exp %h/%b", it.tag, it.c, w32, b32, it.e32, it.i32);
            end
            if (w64 !== it.e64 || b64 !== it.i64) begin
                n_err++;
                $display("FAIL %s rv64 c=%h: got %h/%b exp %h/%b", it.tag, it.c, w64, b64, it.e64, it.i64);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        cin = 16'h0000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset-state word (quadrant 0) and quadrant 2
        same(16'h0000, 32'h0, 1'b1, "R1 quadrant0");
        same(16'h0002, 32'h0, 1'b1, "R1 quadrant2");
        same(16'hFFFF, 32'h0, 1'b1, "R1 quadrant3");
        // R2
        same(c_ci(3'b000, 5'd5, 6'h3D), e_i(12'hFFD, 5'd5, 3'b000, 5'd5, 7'h13), 1'b0, "R2 addi neg");
        same(c_ci(3'b000, 5'd5, 6'h00), e_i(12'h000, 5'd5, 3'b000, 5'd5, 7'h13), 1'b0, "R2 addi hint");
        same(c_ci(3'b010, 5'd10, 6'h1F), e_i(12'h01F, 5'd0, 3'b000, 5'd10, 7'h13), 1'b0, "R2 li");
        same(c_grp(1'b1, 2'b10, 3'd1, 5'd0), e_i(12'hFE0, 5'd9, 3'b111, 5'd9, 7'h13), 1'b0, "R2 andi R11");
        // R3
        push(16'h2C79, 32'h29E000EF, 1'b0, e_i(12'd30, 5'd24, 3'b000, 5'd24, 7'h1B), 1'b0, "R3 link/addiw");
        push(c_cj(3'b001, 12'hFFE), e_j(21'h1FFFFE, 5'd1), 1'b0,
             e_i(12'hFFF, 5'd31, 3'b000, 5'd31, 7'h1B), 1'b0, "R3 neg");
        // R4
        same(c_cj(3'b101, 12'h800), e_j(21'h1FF800, 5'd0), 1'b0, "R4 j min");
        same(c_cj(3'b101, 12'h7FE), e_j(21'h0007FE, 5'd0), 1'b0, "R4 j max");
        same(c_cj(3'b101, 12'h554), e_j(21'h000554, 5'd0), 1'b0, "R4 j alt");
        // R5
        same(c_cb(3'b110, 3'd3, 9'h1FE), e_b(13'h1FFE, 5'd11, 3'b000), 1'b0, "R5 beqz");
        same(c_cb(3'b111, 3'd7, 9'h0FE), e_b(13'h00FE, 5'd15, 3'b001), 1'b0, "R5 bnez");
        same(c_cb(3'b111, 3'd0, 9'h12A), e_b(13'h1F2A, 5'd8, 3'b001), 1'b0, "R5 bnez alt");
        // R6
        same(c_sp(10'h200), e_i(12'hE00, 5'd2, 3'b000, 5'd2, 7'h13), 1'b0, "R6 sp min");
        same(c_sp(10'h1F0), e_i(12'h1F0, 5'd2, 3'b000, 5'd2, 7'h13), 1'b0, "R6 sp max");
        same(c_sp(10'h0A0), e_i(12'h0A0, 5'd2, 3'b000, 5'd2, 7'h13), 1'b0, "R6 sp alt");
        same(c_ci(3'b011, 5'd2, 6'h00), 32'h0, 1'b1, "R6 sp zero");
        // R7
        same(c_ci(3'b011, 5'd7, 6'h01), {20'h00001, 5'd7, 7'h37}, 1'b0, "R7 lui pos");
        same(c_ci(3'b011, 5'd7, 6'h3F), {20'hFFFFF, 5'd7, 7'h37}, 1'b0, "R7 lui neg");
        same(c_ci(3'b011, 5'd7, 6'h00), 32'h0, 1'b1, "R7 lui zero");
        same(c_ci(3'b011, 5'd0, 6'h05), {20'h00005, 5'd0, 7'h37}, 1'b0, "R7 lui hint");
        // R8
        same(c_grp(1'b0, 2'b00, 3'd0, 5'd3), e_i(12'h003, 5'd8, 3'b101, 5'd8, 7'h13), 1'b0, "R8 srli");
        same(c_grp(1'b0, 2'b01, 3'd4, 5'd31), e_i(12'h41F, 5'd12, 3'b101, 5'd12, 7'h13), 1'b0, "R8 srai");
        push(c_grp(1'b1, 2'b00, 3'd2, 5'd0), 32'h0, 1'b1,
             e_i(12'h020, 5'd10, 3'b101, 5'd10, 7'h13), 1'b0, "R8 srli sh32");
        push(c_grp(1'b1, 2'b01, 3'd2, 5'd1), 32'h0, 1'b1,
             e_i(12'h421, 5'd10, 3'b101, 5'd10, 7'h13), 1'b0, "R8 srai sh33");
        // R9
        same(c_grp(1'b0, 2'b11, 3'd0, {2'b00, 3'd1}), e_r(7'h20, 5'd9, 5'd8, 3'b000, 7'h33), 1'b0, "R9 sub");
        same(c_grp(1'b0, 2'b11, 3'd2, {2'b01, 3'd3}), e_r(7'h00, 5'd11, 5'd10, 3'b100, 7'h33), 1'b0, "R9 xor");
        same(c_grp(1'b0, 2'b11, 3'd6, {2'b10, 3'd7}), e_r(7'h00, 5'd15, 5'd14, 3'b110, 7'h33), 1'b0, "R9 or");
        same(c_grp(1'b0, 2'b11, 3'd5, {2'b11, 3'd0}), e_r(7'h00, 5'd8, 5'd13, 3'b111, 7'h33), 1'b0, "R9 and");
        // R10
        push(c_grp(1'b1, 2'b11, 3'd1, {2'b00, 3'd2}), 32'h0, 1'b1,
             e_r(7'h20, 5'd10, 5'd9, 3'b000, 7'h3B), 1'b0, "R10 subw");
        push(c_grp(1'b1, 2'b11, 3'd3, {2'b01, 3'd4}), 32'h0, 1'b1,
             e_r(7'h00, 5'd12, 5'd11, 3'b000, 7'h3B), 1'b0, "R10 addw");
        same(c_grp(1'b1, 2'b11, 3'd3, {2'b10, 3'd4}), 32'h0, 1'b1, "R10 reserved10");
        same(c_grp(1'b1, 2'b11, 3'd3, {2'b11, 3'd4}), 32'h0, 1'b1, "R10 reserved11");
        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL scoreboard left %0d items", sb_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule